// File: doc/BRIEF.md
# Timer DMA Burst Redirector

A single timer event can start a run of DMA requests. Every transfer in that run uses one virtual data address, and the block steers each access to a different real timer register. The DMA controller keeps reading from or writing to the same location. The redirector adds a running transfer index to a programmed base offset and sends the access to that target register. This lets software reprogram several timer registers, or sample them, on every event without the processor taking part.

A 5-bit base field and a 5-bit length field are captured when an event starts a burst. The captured base is a word offset from the first control register: offset 0 is the first control register, 1 is the second control register and 2 is the slave-mode control register. The captured length value n gives n+1 transfers. Accesses to any other bus address go straight to the register at that word offset. The timer registers are modelled as a plain array of words with byte enables, so a transfer can write a single half-word, for example into one of the compare registers.

Top module: `dma_burst_redirect`

## Requirements
- R1: After reset, dmaReq is 0 and every implemented register reads as 0.
- R2: An event seen while idle raises dmaReq on the next cycle. dmaReq then stays high until the burst completes.
- R3: A captured length value n gives exactly n+1 transfers. dmaReq goes low in the cycle after the edge that accepts the last transfer.
- R4: A transfer is a cycle where busSel is high, busAddr equals the virtual address (63 by default) and dmaAck is high while dmaReq is high. Transfer k (k counts from 0) writes the register at word offset base+k.
- R5: During transfer k, busRdata returns the current contents of the register at base+k.
- R6: Base and length are sampled only on the event that starts a burst. Changing them during a burst has no effect on that burst.
- R7: An event that arrives while a burst is running has no effect, even in the cycle of the last transfer. The running burst neither restarts nor lengthens.
- R8: A write changes only the byte lanes whose busByteEn bit is 1. Bit i enables bits 8i+7..8i.
- R9: Any effective register offset at or above the implemented count (24 by default) reads as 0, and writes to it are dropped.
- R10: An access to any address other than the virtual one goes to the register at that word offset. It does not advance the burst index.
- R11: A virtual-address access reads as 0, does not write and does not advance the index in two cases: when no burst is running, or when dmaAck is low.
- R12: busRdata is 0 whenever busSel is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trigEvent | input | 1 | Timer event that starts a burst |
| burstBase | input | 5 | First target word offset |
| burstLen | input | 5 | Transfer count minus one |
| busSel | input | 1 | Register bus access strobe |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 6 | Word offset of the access |
| busByteEn | input | 4 | Byte-lane write enables |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data (combinational) |
| dmaReq | output | 1 | DMA request, high during a burst |
| dmaAck | input | 1 | DMA acknowledge for the current access |

## Verification
Bursts are run with several base and length settings, covering both writes and reads. Some bursts are acknowledged on every cycle and others have unacknowledged virtual accesses between transfers, which separates index advance from plain address decoding. Half-word lane writes, direct accesses placed inside a burst, and events or field changes during a burst show whether configuration and index are held correctly. Bursts that run past the register count, length zero, the largest length, and an event on the final transfer probe the end-of-burst boundary.

// File: rtl/dma_burst_pkg.sv
package dma_burst_pkg;

  // Control-to-datapath strobes
  typedef struct packed {
    logic captureCfg;   // latch base/length, clear index
    logic xferStep;     // acknowledged virtual access this cycle
    logic burstActive;  // a burst is running
  } burst_strobe_t;

  typedef enum logic {ST_IDLE, ST_BURST} burst_state_t;

endpackage

// File: rtl/dma_burst_ctrl.sv
module dma_burst_ctrl
  import dma_burst_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          trigEvent,
  input  logic          virtHit,
  input  logic          dmaAck,
  input  logic          isLast,
  output logic          dmaReq,
  output burst_strobe_t strb
);

  burst_state_t state, stateNext;

  always_comb begin
    strb      = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (trigEvent) begin
          strb.captureCfg = 1'b1;
          stateNext       = ST_BURST;
        end
      end
      ST_BURST: begin
        strb.burstActive = 1'b1;
        if (virtHit && dmaAck) begin
          strb.xferStep = 1'b1;
          if (isLast) stateNext = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign dmaReq = (state == ST_BURST);

  assert_req_after_event_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!dmaReq && trigEvent) |=> dmaReq);

  assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!dmaReq && !trigEvent) |=> !dmaReq);

  assert_req_drop_last_R3: assert property (@(posedge clk) disable iff (!rstN)
    (dmaReq && virtHit && dmaAck && isLast) |=> !dmaReq);

  assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (dmaReq && !(virtHit && dmaAck)) |=> dmaReq);

endmodule

// File: rtl/dma_burst_datapath.sv
module dma_burst_datapath
  import dma_burst_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 6,
  parameter int NUM_REGS  = 24,
  parameter int VIRT_ADDR = 63,
  parameter int BASE_W    = 5,
  parameter int LEN_W     = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  burst_strobe_t       strb,
  input  logic [BASE_W-1:0]   burstBase,
  input  logic [LEN_W-1:0]    burstLen,
  input  logic                busSel,
  input  logic                busWrite,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W/8-1:0] busByteEn,
  input  logic [DATA_W-1:0]   busWdata,
  output logic [DATA_W-1:0]   busRdata,
  output logic                virtHit,
  output logic                isLast
);

  localparam int BE_W  = DATA_W / 8;
  localparam int TGT_W = ((BASE_W > LEN_W) ? BASE_W : LEN_W) + 1;
  localparam int EFF_W = (ADDR_W > TGT_W) ? ADDR_W : TGT_W;

  logic [BASE_W-1:0] capBase;
  logic [LEN_W-1:0]  capLen;
  logic [LEN_W-1:0]  idx;

  // Burst configuration and transfer index
  always_ff @(posedge clk) begin
    if (!rstN) begin
      capBase <= '0;
      capLen  <= '0;
      idx     <= '0;
    end else if (strb.captureCfg) begin
      capBase <= burstBase;
      capLen  <= burstLen;
      idx     <= '0;
    end else if (strb.xferStep) begin
      idx <= idx + LEN_W'(1);
    end
  end

  assign isLast  = (idx == capLen);
  assign virtHit = busSel && (busAddr == ADDR_W'(VIRT_ADDR));

  // Effective target selection
  logic [EFF_W-1:0] target;
  logic [EFF_W-1:0] effAddr;
  logic             effValid;
  logic             inRange;
  logic             wrEn;

  assign target = EFF_W'(capBase) + EFF_W'(idx);

  always_comb begin
    if (virtHit) begin
      effValid = strb.xferStep;
      effAddr  = target;
    end else begin
      effValid = busSel;
      effAddr  = EFF_W'(busAddr);
    end
  end

  assign inRange = effValid && (effAddr < EFF_W'(NUM_REGS));
  assign wrEn    = inRange && busWrite;

  // Target register array
  logic [DATA_W-1:0] regs [NUM_REGS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < NUM_REGS; r++) regs[r] <= '0;
    end else if (wrEn) begin
      for (int r = 0; r < NUM_REGS; r++) begin
        if (effAddr == EFF_W'(r)) begin
          for (int b = 0; b < BE_W; b++) begin
            if (busByteEn[b]) regs[r][b*8 +: 8] <= busWdata[b*8 +: 8];
          end
        end
      end
    end
  end

  always_comb begin
    busRdata = '0;
    for (int r = 0; r < NUM_REGS; r++) begin
      if (inRange && (effAddr == EFF_W'(r))) busRdata = regs[r];
    end
  end

  assert_idx_bounded_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.burstActive |-> (idx <= capLen));

  assert_cfg_held_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.burstActive && !strb.captureCfg) |=> ($stable(capBase) && $stable(capLen)));

endmodule

// File: rtl/dma_burst_redirect.sv
module dma_burst_redirect
  import dma_burst_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 6,
  parameter int NUM_REGS  = 24,
  parameter int VIRT_ADDR = 63,
  parameter int BASE_W    = 5,
  parameter int LEN_W     = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                trigEvent,
  input  logic [BASE_W-1:0]   burstBase,
  input  logic [LEN_W-1:0]    burstLen,
  input  logic                busSel,
  input  logic                busWrite,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W/8-1:0] busByteEn,
  input  logic [DATA_W-1:0]   busWdata,
  output logic [DATA_W-1:0]   busRdata,
  output logic                dmaReq,
  input  logic                dmaAck
);

  burst_strobe_t strb;
  logic          virtHit;
  logic          isLast;

  dma_burst_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .trigEvent (trigEvent),
    .virtHit   (virtHit),
    .dmaAck    (dmaAck),
    .isLast    (isLast),
    .dmaReq    (dmaReq),
    .strb      (strb)
  );

  dma_burst_datapath #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .NUM_REGS  (NUM_REGS),
    .VIRT_ADDR (VIRT_ADDR),
    .BASE_W    (BASE_W),
    .LEN_W     (LEN_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .burstBase (burstBase),
    .burstLen  (burstLen),
    .busSel    (busSel),
    .busWrite  (busWrite),
    .busAddr   (busAddr),
    .busByteEn (busByteEn),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .virtHit   (virtHit),
    .isLast    (isLast)
  );

  assert_rdata_quiet_R12: assert property (@(posedge clk) disable iff (!rstN)
    !busSel |-> (busRdata == '0));

endmodule

// File: tb/dma_burst_redirect_tb.sv
module dma_burst_redirect_tb;

  localparam int NUM  = 24;
  localparam int VIRT = 63;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        trigEvent = 1'b0;
  logic [4:0]  burstBase = '0;
  logic [4:0]  burstLen = '0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [5:0]  busAddr = '0;
  logic [3:0]  busByteEn = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        dmaReq;
  logic        dmaAck = 1'b0;

  int checks = 0;
  int fails = 0;

  // Behavioural reference
  logic [31:0] mRegs [NUM];
  bit          mActive = 0;
  int          mIdx = 0, mBase = 0, mLen = 0;

  always #5 clk = ~clk;

  dma_burst_redirect u_dut (
    .clk(clk), .rstN(rstN), .trigEvent(trigEvent), .burstBase(burstBase),
    .burstLen(burstLen), .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .busByteEn(busByteEn), .busWdata(busWdata), .busRdata(busRdata),
    .dmaReq(dmaReq), .dmaAck(dmaAck)
  );

  task automatic check32(input logic [31:0] act, input logic [31:0] exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // One clock: drive inputs, compare against the model, then advance the model.
  task automatic tick(input bit ev, input int b, input int l, input bit sel, input bit wr,
                      input int a, input logic [3:0] be, input logic [31:0] wd,
                      input bit ack, input string tag);
    bit virt, step, valid;
    int eff;
    logic [31:0] exp;
    @(negedge clk);
    trigEvent = ev; burstBase = 5'(b); burstLen = 5'(l);
    busSel = sel; busWrite = wr; busAddr = 6'(a); busByteEn = be; busWdata = wd; dmaAck = ack;
    #1;
    virt = sel && (a == VIRT);
    step = mActive && virt && ack;
    if (virt) begin valid = step; eff = mBase + mIdx; end
    else begin valid = sel; eff = a; end
    exp = (valid && eff < NUM) ? mRegs[eff] : 32'h0;
    check32(busRdata, exp, tag, "busRdata");
    check32({31'h0, dmaReq}, {31'h0, mActive}, tag, "dmaReq");
    @(posedge clk);
    if (valid && wr && eff < NUM)
      for (int i = 0; i < 4; i++) if (be[i]) mRegs[eff][i*8 +: 8] = wd[i*8 +: 8];
    if (step) begin
      if (mIdx == mLen) mActive = 0; else mIdx++;
    end else if (!mActive && ev) begin
      mActive = 1; mIdx = 0; mBase = b; mLen = l;
    end
  endtask

  task automatic idle(input string tag);
    tick(0, 0, 0, 0, 0, 0, 4'h0, 32'h0, 0, tag);
  endtask

  task automatic rd(input int a, input string tag);
    tick(0, 0, 0, 1, 0, a, 4'h0, 32'h0, 0, tag);
  endtask

  task automatic vwr(input logic [31:0] d, input logic [3:0] be, input string tag);
    tick(0, 0, 0, 1, 1, VIRT, be, d, 1, tag);
  endtask

  task automatic start(input int b, input int l, input string tag);
    tick(1, b, l, 0, 0, 0, 4'h0, 32'h0, 0, tag);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #1000000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    for (int i = 0; i < NUM; i++) mRegs[i] = 32'h0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R1: reset state
    idle("R1");
    for (int r = 0; r < NUM; r++) rd(r, "R1");

    // R10: direct writes
    for (int r = 0; r < NUM; r++) tick(0, 0, 0, 1, 1, r, 4'hF, 32'hA000_0000 + r * 32'h111, 0, "R10");
    for (int r = 0; r < NUM; r++) rd(r, "R10");

    // R12: no select, no read data
    tick(0, 0, 0, 0, 0, 5, 4'h0, 32'h0, 0, "R12");

    // R2/R4/R3: write burst base 3, length 2 (three transfers)
    start(3, 2, "R2");
    idle("R2");
    for (int k = 0; k < 3; k++) vwr(32'hB000_0000 + k, 4'hF, "R4");
    idle("R3");
    for (int r = 2; r < 7; r++) rd(r, "R4");

    // R5/R11: read burst with unacknowledged accesses between transfers
    start(0, 4, "R2");
    for (int k = 0; k < 5; k++) begin
      tick(0, 0, 0, 1, 1, VIRT, 4'hF, 32'hDEAD_0000, 0, "R11");
      tick(0, 0, 0, 1, 0, VIRT, 4'h0, 32'h0, 1, "R5");
    end
    idle("R3");
    for (int r = 0; r < 5; r++) rd(r, "R11");

    // R8: half-word lanes
    start(8, 1, "R2");
    vwr(32'h1111_2222, 4'b0011, "R8");
    vwr(32'h3333_4444, 4'b1100, "R8");
    rd(8, "R8"); rd(9, "R8");

    // R6/R7: field changes and events during a burst
    start(12, 3, "R2");
    for (int k = 0; k < 4; k++) tick(1, 0, 0, 1, 1, VIRT, 4'hF, 32'hC000_0000 + k, 1, "R7");
    idle("R6");
    for (int r = 0; r < 17; r++) rd(r, "R6");

    // R10: direct access inside a burst does not advance the index
    start(4, 1, "R2");
    tick(0, 0, 0, 1, 1, 20, 4'hF, 32'h5555_AAAA, 1, "R10");
    vwr(32'hE000_0004, 4'hF, "R10");
    vwr(32'hE000_0005, 4'hF, "R10");
    idle("R10");
    rd(4, "R10"); rd(5, "R10"); rd(6, "R10"); rd(20, "R10");

    // R9: burst running past the implemented registers
    start(20, 7, "R2");
    for (int k = 0; k < 8; k++) vwr(32'hF000_0000 + k, 4'hF, "R9");
    start(20, 7, "R2");
    for (int k = 0; k < 8; k++) tick(0, 0, 0, 1, 0, VIRT, 4'h0, 32'h0, 1, "R9");
    tick(0, 0, 0, 1, 1, 30, 4'hF, 32'h1234_5678, 0, "R9");
    rd(30, "R9");

    // R11: virtual access while idle
    vwr(32'h7777_7777, 4'hF, "R11");
    rd(0, "R11");

    // R3: single transfer, then maximum length
    start(0, 0, "R2");
    vwr(32'h0000_00AA, 4'hF, "R3");
    idle("R3");
    start(31, 31, "R2");
    for (int k = 0; k < 32; k++) vwr(32'h9, 4'hF, "R3");
    idle("R3");

    // R7: event on the final transfer is ignored
    start(1, 1, "R2");
    vwr(32'h0101_0101, 4'hF, "R7");
    tick(1, 10, 3, 1, 1, VIRT, 4'hF, 32'h0202_0202, 1, "R7");
    idle("R7");
    idle("R7");
    rd(1, "R7"); rd(2, "R7"); rd(10, "R7");

    summary();
  end

endmodule